// File: doc/BRIEF.md
# Single-Byte-Buffered Serial Port with APB Register Access

This block is a memory-mapped asynchronous serial port. Software reaches it through an APB slave with no wait states. It sends and receives characters with a fixed frame: one start bit, eight data bits sent least significant first, and one stop bit. There is no parity. A 20-bit integer divisor sets the bit time, so one bit lasts exactly that many PCLK cycles.

Each direction holds a single byte and has no queue. Software writes the transmit byte into a data register, and reading the same register returns the last received byte. Full flags and overrun flags report the state of both buffers. Control bits enable each direction and each interrupt source. Sticky status bits latch "transmit done" and "receive done". The overrun interrupt bits always follow the overrun flags gated by their enables. Five interrupt lines leave the block: one per source and one combined line.

Inside the block, the register file hands each transmit byte to the shifter over a valid/ready pair. The handoff happens only when the shifter is idle, which gives back-pressure. A software write never stalls. A write into a full buffer is recorded as an overrun. The receiver produces a valid-only stream and cannot be held off, so a byte that arrives while the buffer is still full overwrites the held byte and raises the receive overrun flag.

Top module: `serial_port_apb`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0. A read from any offset that has no register returns 0.
- R2: Twelve read-only identification words are mapped at 0xFD0 to 0xFFC, one every 4 bytes. They read 04,00,00,00,21,B8,1B,00,0D,F0,05,B1 in order of address, so 0xFD0 reads 0x04, 0xFE0 reads 0x21, 0xFF0 reads 0x0D and 0xFFC reads 0xB1. Writes to them have no effect.
- R3: The control register at 0x08 keeps bits [6:0] and drops all higher bits. Its fields are: bit 0 transmit enable, bit 1 receive enable, bit 2 transmit-done interrupt enable, bit 3 receive-done interrupt enable, bit 4 transmit-overrun interrupt enable, bit 5 receive-overrun interrupt enable, bit 6 a stored test bit. The divisor register at 0x10 keeps bits [19:0].
- R4: Writing the data register at 0x00 while the transmit-full flag (status register 0x04, bit 0) is clear stores the byte and sets the flag. When transmission is enabled and the divisor is valid, `txd` then sends a low start bit, the 8 data bits LSB first and a high stop bit. Each bit lasts divisor cycles. `txd` idles high.
- R5: The transmit-full flag clears when the stop bit ends. If bit 2 of the control register is set at that moment, the transmit-done status (0x0C, bit 0) becomes 1.
- R6: Writing the data register while the transmit-full flag is set sets the transmit-overrun flag (0x04, bit 2) and does not disturb the frame already in progress.
- R7: When a character completes with receive enabled, the byte is stored and the receive-full flag (0x04, bit 1) is set. If bit 3 of the control register is set, the receive-done status (0x0C, bit 1) is set too. Reading 0x00 returns the byte and clears the receive-full flag.
- R8: A character that completes while the receive-full flag is already set replaces the stored byte and sets the receive-overrun flag (0x04, bit 3).
- R9: Characters that arrive while receive is disabled are dropped and leave the receive-full flag at 0.
- R10: In 0x0C, bits 2 and 3 read as the transmit-overrun and receive-overrun flags each ANDed with its control enable (control bits 4 and 5). Writing 1 to either of these bits, in 0x0C or at the same bit of 0x04, clears the flag itself. Bits 0 and 1 of 0x04 ignore writes.
- R11: Bits 0 and 1 of 0x0C stay set until a 1 is written to them. The outputs `irq_tx`, `irq_rx`, `irq_tx_ovr` and `irq_rx_ovr` follow bits 0 to 3 of 0x0C, and `irq_any` is the OR of those four bits.
- R12: While the divisor is below 16, no frame starts: `txd` stays high and a pending byte keeps the transmit-full flag set.
- R13: After reset, every register reads 0, both buffers are empty, `txd` is high and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and bit-timing clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive-done interrupt |
| irq_tx_ovr | output | 1 | Transmit-overrun interrupt |
| irq_rx_ovr | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of all interrupt status bits |

## Verification
Transmission is tried with alternating bit patterns (0x55), with a mixed byte (0xA3) and with two back-to-back writes. Together these separate bit order and bit length errors from buffer-replacement errors. In the back-to-back case a second frame, or a frame carrying the replacing byte, shows that an overwrite leaked into the line. Reception is tried with a single byte, with two bytes arriving without a read in between, and with receive disabled. These cases separate storing from overrun and from dropping. A divisor below the minimum, followed by a legal divisor, shows that a pending byte is held back and then released rather than lost.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned OFF_DATA = 'h000;
  localparam int unsigned OFF_STAT = 'h004;
  localparam int unsigned OFF_CTRL = 'h008;
  localparam int unsigned OFF_INTS = 'h00C;
  localparam int unsigned OFF_DIV  = 'h010;
  localparam int unsigned OFF_ID_LO = 'hFD0;
  localparam int unsigned OFF_ID_HI = 'hFFC;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:  id_byte = 8'h04;
      4'd4:  id_byte = 8'h21;
      4'd5:  id_byte = 8'hB8;
      4'd6:  id_byte = 8'h1B;
      4'd8:  id_byte = 8'h0D;
      4'd9:  id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sp_tx_shift.sv
module sp_tx_shift #(
  parameter int DBITS = 8,
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DBITS-1:0] in_data,
  output logic             done,
  output logic             txd
);
  localparam int FBITS = DBITS + 2;
  localparam int IDX_W = $clog2(FBITS + 1);

  logic [FBITS-1:0] shreg;
  logic [DIV_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             busy;

  assign in_ready = ~busy;
  assign txd      = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      cnt   <= '0;
      idx   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          shreg <= {1'b1, in_data, 1'b0};
          cnt   <= '0;
          idx   <= '0;
          busy  <= 1'b1;
        end
      end else if (cnt == div - 1'b1) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FBITS-1:1]};
        if (idx == IDX_W'(FBITS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_line_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/sp_rx_sample.sv
module sp_rx_sample
  import sp_pkg::*;
#(
  parameter int DBITS = 8,
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             out_valid,
  output logic [DBITS-1:0] out_data
);
  localparam int IDX_W = $clog2(DBITS + 1);

  logic [1:0]       sync;
  logic             line;
  rx_state_t        st;
  logic [DIV_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DBITS-1:0] sh;
  logic [DIV_W-1:0] half;

  assign line = sync[1];
  assign half = div >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: if (cnt == half - 1'b1) begin
            cnt <= '0;
            idx <= '0;
            st  <= line ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
          RX_DATA: if (cnt == div - 1'b1) begin
            cnt <= '0;
            sh  <= {line, sh[DBITS-1:1]};
            if (idx == IDX_W'(DBITS - 1)) st <= RX_STOP;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          default: if (cnt == div - 1'b1) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (line) begin
              out_valid <= 1'b1;
              out_data  <= sh;
            end
          end else cnt <= cnt + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port_apb.sv
module serial_port_apb
  import sp_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DIV_W   = 20,
  parameter int DBITS   = 8,
  parameter int MIN_DIV = 16,
  parameter int CTRL_W  = 7
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_tx_ovr,
  output logic              irq_rx_ovr,
  output logic              irq_any
);
  logic              acc, wr, rd;
  logic              wr_data, wr_stat, wr_ctrl, wr_ints, wr_div, rd_data;
  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  baud;
  logic [DBITS-1:0]  tx_buf, rx_buf, rx_byte;
  logic              tx_full, rx_full, tx_ovr, rx_ovr, int_tx, int_rx, tx_sent;
  logic              div_ok, tx_valid, tx_ready, tx_done, rx_valid, rx_take;
  logic [3:0]        ints;
  logic              unused_bits;

  assign acc     = psel & penable;
  assign wr      = acc & pwrite;
  assign rd      = acc & ~pwrite;
  assign wr_data = wr && paddr == ADDR_W'(OFF_DATA);
  assign wr_stat = wr && paddr == ADDR_W'(OFF_STAT);
  assign wr_ctrl = wr && paddr == ADDR_W'(OFF_CTRL);
  assign wr_ints = wr && paddr == ADDR_W'(OFF_INTS);
  assign wr_div  = wr && paddr == ADDR_W'(OFF_DIV);
  assign rd_data = rd && paddr == ADDR_W'(OFF_DATA);
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign unused_bits = ^pwdata[31:DIV_W];

  assign div_ok   = baud >= DIV_W'(MIN_DIV);
  assign tx_valid = tx_full & ctrl[0] & div_ok & ~tx_sent;
  assign rx_take  = rx_valid & ctrl[1];

  sp_tx_shift #(.DBITS(DBITS), .DIV_W(DIV_W)) u_tx (
    .clk(pclk), .rst_n(presetn), .div(baud),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_buf),
    .done(tx_done), .txd(txd));

  sp_rx_sample #(.DBITS(DBITS), .DIV_W(DIV_W)) u_rx (
    .clk(pclk), .rst_n(presetn), .en(ctrl[1] & div_ok), .div(baud),
    .rxd(rxd), .out_valid(rx_valid), .out_data(rx_byte));

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl <= '0; baud <= '0; tx_buf <= '0; rx_buf <= '0;
      tx_full <= 1'b0; rx_full <= 1'b0; tx_ovr <= 1'b0; rx_ovr <= 1'b0;
      int_tx <= 1'b0; int_rx <= 1'b0; tx_sent <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= pwdata[CTRL_W-1:0];
      if (wr_div)  baud <= pwdata[DIV_W-1:0];
      // overrun clears, from either register
      if ((wr_stat | wr_ints) & pwdata[2]) tx_ovr <= 1'b0;
      if ((wr_stat | wr_ints) & pwdata[3]) rx_ovr <= 1'b0;
      if (wr_ints & pwdata[0]) int_tx <= 1'b0;
      if (wr_ints & pwdata[1]) int_rx <= 1'b0;
      // transmit path
      if (tx_valid & tx_ready) tx_sent <= 1'b1;
      if (tx_done) begin
        tx_full <= 1'b0;
        tx_sent <= 1'b0;
        if (ctrl[2]) int_tx <= 1'b1;
      end
      if (wr_data) begin
        tx_buf <= pwdata[DBITS-1:0];
        if (tx_full & ~tx_done) tx_ovr  <= 1'b1;
        else                    tx_full <= 1'b1;
      end
      // receive path
      if (rd_data) rx_full <= 1'b0;
      if (rx_take) begin
        rx_buf  <= rx_byte;
        rx_full <= 1'b1;
        if (rx_full & ~rd_data) rx_ovr <= 1'b1;
        if (ctrl[3]) int_rx <= 1'b1;
      end
    end
  end

  assign ints = {rx_ovr & ctrl[5], tx_ovr & ctrl[4], int_rx, int_tx};
  assign irq_tx     = ints[0];
  assign irq_rx     = ints[1];
  assign irq_tx_ovr = ints[2];
  assign irq_rx_ovr = ints[3];
  assign irq_any    = |ints;

  always_comb begin
    prdata = '0;
    if (rd) begin
      if (paddr == ADDR_W'(OFF_DATA))      prdata[DBITS-1:0]  = rx_buf;
      else if (paddr == ADDR_W'(OFF_STAT)) prdata[3:0]        = {rx_ovr, tx_ovr, rx_full, tx_full};
      else if (paddr == ADDR_W'(OFF_CTRL)) prdata[CTRL_W-1:0] = ctrl;
      else if (paddr == ADDR_W'(OFF_INTS)) prdata[3:0]        = ints;
      else if (paddr == ADDR_W'(OFF_DIV))  prdata[DIV_W-1:0]  = baud;
      else if (paddr >= ADDR_W'(OFF_ID_LO) && paddr <= ADDR_W'(OFF_ID_HI) && paddr[1:0] == 2'b00)
        prdata[7:0] = id_byte(4'((paddr - ADDR_W'(OFF_ID_LO)) >> 2));
    end
  end

  p_zero_wait_r1: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);
  p_full_clear_r5: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(tx_full) |-> $past(tx_done));
  p_tx_overrun_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_data && tx_full && !tx_done) |=> tx_ovr);
  p_rx_overrun_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (rx_take && rx_full && !rd_data) |=> rx_ovr);
  p_no_start_r12: assert property (@(posedge pclk) disable iff (!presetn)
    (!div_ok && !tx_sent) |=> !tx_sent);
endmodule

// File: tb/sim_serial_port_apb.sv
module sim_serial_port_apb;
  localparam int DIV = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0, rxd = 1'b1;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, txd, irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any;
  int checks = 0, fails = 0, frames = 0, pushed = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  serial_port_apb u0 (.pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_tx_ovr(irq_tx_ovr), .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    apb_rd(a, v);
    chk(v === exp, req, v, exp);
  endtask

  // driver: queue the expected byte and write it
  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b); pushed++;
    apb_wr(12'h000, {24'h0, b});
  endtask

  task automatic wait_frames;
    while (frames != pushed) @(posedge clk);
    repeat (16) @(posedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rxd = 0; repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (DIV) @(negedge clk); end
    rxd = 1; repeat (DIV) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decode txd and compare to the scoreboard
  initial begin
    logic [7:0] got, exp;
    @(posedge rst_n);
    forever begin
      @(negedge txd);
      repeat (DIV/2) @(posedge clk); #1;
      chk(txd === 1'b0, "R4 start bit", {31'h0, txd}, 0);
      for (int i = 0; i < 8; i++) begin repeat (DIV) @(posedge clk); #1; got[i] = txd; end
      repeat (DIV) @(posedge clk); #1;
      chk(txd === 1'b1, "R4 stop bit", {31'h0, txd}, 1);
      if (exp_q.size() == 0) chk(0, "R4 unexpected frame", {24'h0, got}, 0);
      else begin exp = exp_q.pop_front(); chk(got === exp, "R4 frame data", {24'h0, got}, {24'h0, exp}); end
      frames++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int lows;
    repeat (3) @(negedge clk); rst_n = 1;
    // R13 reset state
    #1 chk(txd === 1 && irq_any === 0, "R13 outputs", {30'h0, txd, irq_any}, 32'h2);
    rd_chk(12'h004, 0, "R13 status"); rd_chk(12'h008, 0, "R13 ctrl");
    rd_chk(12'h00C, 0, "R13 ints");   rd_chk(12'h010, 0, "R13 divisor");
    // R1
    chk(pready === 1 && pslverr === 0, "R1 handshake", {30'h0, pready, pslverr}, 32'h2);
    rd_chk(12'h014, 0, "R1 unmapped");
    // R2
    rd_chk(12'hFD0, 32'h04, "R2 id lo"); rd_chk(12'hFE0, 32'h21, "R2 id 0xFE0");
    rd_chk(12'hFF0, 32'h0D, "R2 id 0xFF0"); rd_chk(12'hFFC, 32'hB1, "R2 id hi");
    apb_wr(12'hFE0, 32'hFF); rd_chk(12'hFE0, 32'h21, "R2 write ignored");
    // R3
    apb_wr(12'h008, 32'hFFFF_FFFF); rd_chk(12'h008, 32'h7F, "R3 ctrl mask");
    apb_wr(12'h010, 32'hFFFF_FFFF); rd_chk(12'h010, 32'hFFFFF, "R3 divisor mask");
    // R12 invalid divisor holds the byte
    apb_wr(12'h010, 8); apb_wr(12'h008, 32'h3F);
    send_tx(8'h55);
    lows = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk(lows == 0, "R12 line idle", lows, 0);
    rd_chk(12'h004, 1, "R12 still full");
    apb_wr(12'h010, DIV);
    wait_frames;
    apb_wr(12'h00C, 1);
    // R4/R5
    send_tx(8'hA3); wait_frames;
    rd_chk(12'h004, 0, "R5 full cleared");
    rd_chk(12'h00C, 1, "R5 tx status");
    chk(irq_tx === 1 && irq_any === 1, "R11 irq_tx", {30'h0, irq_tx, irq_any}, 3);
    apb_wr(12'h00C, 1);
    rd_chk(12'h00C, 0, "R11 w1c tx");
    chk(irq_tx === 0, "R11 irq_tx low", {31'h0, irq_tx}, 0);
    // R6 overrun on full
    send_tx(8'h11);
    apb_wr(12'h000, 8'h22);
    rd_chk(12'h004, 5, "R6 overrun set");
    chk(irq_tx_ovr === 1, "R11 irq_tx_ovr", {31'h0, irq_tx_ovr}, 1);
    wait_frames;
    rd_chk(12'h004, 4, "R6 frame unaffected");
    // R10 live AND with enable
    apb_wr(12'h008, 32'h2F);
    rd_chk(12'h00C, 1, "R10 masked overrun");
    chk(irq_tx_ovr === 0, "R10 irq masked", {31'h0, irq_tx_ovr}, 0);
    apb_wr(12'h008, 32'h3F);
    apb_wr(12'h00C, 32'h5);
    rd_chk(12'h004, 0, "R10 clear via ints");
    rd_chk(12'h00C, 0, "R10 ints clear");
    // R7 receive
    send_rx(8'h5A);
    rd_chk(12'h004, 2, "R7 rx full");
    chk(irq_rx === 1, "R7 irq_rx", {31'h0, irq_rx}, 1);
    rd_chk(12'h000, 32'h5A, "R7 data");
    rd_chk(12'h004, 0, "R7 full cleared");
    rd_chk(12'h00C, 2, "R11 rx sticky");
    apb_wr(12'h00C, 2);
    // R8 overrun
    send_rx(8'h01); send_rx(8'h02);
    rd_chk(12'h004, 32'hA, "R8 overrun");
    chk(irq_rx_ovr === 1, "R8 irq_rx_ovr", {31'h0, irq_rx_ovr}, 1);
    apb_wr(12'h004, 32'hB);
    rd_chk(12'h004, 2, "R10 status w1c, bits 0-1 kept");
    rd_chk(12'h000, 32'h02, "R8 newest byte");
    apb_wr(12'h00C, 2);
    // R9 disabled receive
    apb_wr(12'h008, 32'h3D);
    send_rx(8'h77);
    rd_chk(12'h004, 0, "R9 dropped");
    chk(irq_any === 0, "R9 no irq", {31'h0, irq_any}, 0);
    repeat (50) @(posedge clk);
    chk(frames == pushed, "R6 frame count", frames, pushed);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule